// File: doc/BRIEF.md
# Bus Target Address Phase Decoder

This block sits at the front of a target on a shared bus where address and data travel on the same 32 wires. A frame-start strobe marks the first address cycle. In that cycle the block samples the address word and the 4-bit command code. It sorts the command into a transaction type and decides whether this target claims the access. The target can be claimed through a programmed I/O window, a programmed 64-bit memory window, its configuration select line, or an interrupt acknowledge. The result comes out one cycle later, together with a window-relative register offset and, for configuration accesses, the function number.

When the first cycle carries the dual-address code, the word on the wires is only the low half of a 64-bit address. The block then always takes the next cycle as the high half, and the command code in that second cycle as the real command. The block is a two-state machine:
- `ST_IDLE` waits for a start.
- `ST_DAC_HI` holds the low half for one cycle.

The transitions are:
- `IDLE->DAC_HI` on a start with the dual-address code.
- `IDLE->IDLE` on any other cycle.
- `DAC_HI->IDLE`, taken unconditionally.

The output process registers the decode of every single-cycle start, and of every `ST_DAC_HI` cycle.

I/O commands are byte addressed, so address bits 1:0 take part in the window compare. Memory commands are doubleword addressed, so those two bits are left out.

Top module: `addr_phase_decoder`

## Requirements
- R1: While reset is held, and in any cycle without a decode, `dec_valid`, `hit` and `vec_req` are 0, `txn_type` is 0 (none), and `reg_offset`, `cfg_func` and `vector_out` are 0.
- R2: A start in `ST_IDLE` with a code other than 1101 gives a one-cycle `dec_valid` pulse one clock later. `txn_type` then takes one of these values:
  - 1 for 0000 (interrupt acknowledge)
  - 2 for 0001 (special cycle)
  - 3 for 0010 and 4 for 0011 (I/O read and I/O write)
  - 5 for 0110, 1100 and 1110 (memory read)
  - 6 for 0111 and 1111 (memory write)
  - 7 for 1010 and 8 for 1011 (configuration read and configuration write)
  - 10 for 1101 (dual address, only when it arrives as the second command)
- R3: Codes 0100, 0101, 1000 and 1001 give `txn_type` 9 (reserved) and never a hit.
- R4: An I/O command hits when `((ad_in ^ io_base) & io_mask) == 0` over all 32 bits, including bits 1:0. `reg_offset` is then the low 8 bits of `ad_in & ~io_mask`.
- R5: A memory command hits when the 64-bit address matches `mem_base` under `mem_mask`, with address bits 1:0 always ignored. In a single address cycle the high half of the address is 0. `reg_offset` is the low 8 bits of `addr & ~mem_mask` with bits 1:0 cleared.
- R6: A start with code 1101 gives no decode in its cycle. The next cycle is taken as the high address half and the real command, whatever `frame_start` does in that cycle. The decode appears one clock after that second cycle.
- R7: After a dual-address first cycle, only a memory command can hit. I/O, configuration, interrupt acknowledge and a repeated 1101 are not claimed.
- R8: A configuration command with `cfg_select` high and `ad_in[1:0]` equal to 0 hits. `reg_offset` is then `{ad_in[7:2],2'b00}` and `cfg_func` is `ad_in[10:8]`.
- R9: A configuration command with nonzero `ad_in[1:0]`, or with `cfg_select` low, is not claimed.
- R10: An interrupt acknowledge hits only when `intack_en` is 1. It then raises `vec_req` and presents `irq_vector` on `vector_out`.
- R11: A special cycle is never claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Marks the first address cycle |
| ad_in | input | 32 | Multiplexed address word |
| cbe_in | input | 4 | Command code during the address phase |
| cfg_select | input | 1 | This target is selected for configuration |
| io_base | input | 32 | I/O window base |
| io_mask | input | 32 | I/O window compare mask |
| mem_base | input | 64 | Memory window base |
| mem_mask | input | 64 | Memory window compare mask |
| intack_en | input | 1 | Target answers interrupt acknowledge |
| irq_vector | input | 8 | Vector to present on acknowledge |
| dec_valid | output | 1 | Decode result valid |
| txn_type | output | 4 | Transaction type code |
| hit | output | 1 | Target claims the access |
| reg_offset | output | 8 | Window- or config-relative offset |
| cfg_func | output | 3 | Function number of a config access |
| vec_req | output | 1 | Supply the vector in the data phase |
| vector_out | output | 8 | Interrupt vector |

## Verification
A table walks every command code through single-cycle starts at addresses chosen both inside and outside each window. This separates classification from claiming, and the memory-read variants from the plain read.

Further I/O and memory probes use an all-ones mask and an address whose bits 1:0 are 3. This exposes whether the low-bit rule differs between the two spaces. Misaligned configuration accesses, and accesses with the select line low, are tried alongside aligned ones.

The dual-address runs separate a correct one-cycle wait from a design that restarts on the strobe in the second cycle. They put matching and non-matching high halves behind a memory command, and a non-memory command or a repeated dual code in the second cycle. An acknowledge is tried with the enable off and then on.

// File: rtl/apd_pkg.sv
package apd_pkg;

    typedef enum logic [3:0] {
        CMD_INTACK  = 4'b0000,
        CMD_SPECIAL = 4'b0001,
        CMD_IO_RD   = 4'b0010,
        CMD_IO_WR   = 4'b0011,
        CMD_RSV4    = 4'b0100,
        CMD_RSV5    = 4'b0101,
        CMD_MEM_RD  = 4'b0110,
        CMD_MEM_WR  = 4'b0111,
        CMD_RSV8    = 4'b1000,
        CMD_RSV9    = 4'b1001,
        CMD_CFG_RD  = 4'b1010,
        CMD_CFG_WR  = 4'b1011,
        CMD_MEM_MUL = 4'b1100,
        CMD_DAC     = 4'b1101,
        CMD_MEM_LN  = 4'b1110,
        CMD_MEM_WI  = 4'b1111
    } cmd_e;

    typedef enum logic [3:0] {
        T_NONE     = 4'd0,
        T_INTACK   = 4'd1,
        T_SPECIAL  = 4'd2,
        T_IO_RD    = 4'd3,
        T_IO_WR    = 4'd4,
        T_MEM_RD   = 4'd5,
        T_MEM_WR   = 4'd6,
        T_CFG_RD   = 4'd7,
        T_CFG_WR   = 4'd8,
        T_RESERVED = 4'd9,
        T_DAC      = 4'd10
    } txn_e;

    typedef struct packed {
        txn_e kind;
        logic is_io;
        logic is_mem;
        logic is_cfg;
        logic is_intack;
        logic is_dac;
    } cls_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_DAC_HI = 1'b1
    } st_e;

endpackage

// File: rtl/apd_cmd_classify.sv
module apd_cmd_classify
    import apd_pkg::*;
(
    input  logic [3:0] code,
    output cls_t       cls
);
    always_comb begin
        cls = '{kind: T_RESERVED, is_io: 1'b0, is_mem: 1'b0,
                is_cfg: 1'b0, is_intack: 1'b0, is_dac: 1'b0};
        unique case (code)
            CMD_INTACK:  begin cls.kind = T_INTACK;  cls.is_intack = 1'b1; end
            CMD_SPECIAL: cls.kind = T_SPECIAL;
            CMD_IO_RD:   begin cls.kind = T_IO_RD;   cls.is_io  = 1'b1; end
            CMD_IO_WR:   begin cls.kind = T_IO_WR;   cls.is_io  = 1'b1; end
            CMD_MEM_RD, CMD_MEM_MUL, CMD_MEM_LN:
                         begin cls.kind = T_MEM_RD;  cls.is_mem = 1'b1; end
            CMD_MEM_WR, CMD_MEM_WI:
                         begin cls.kind = T_MEM_WR;  cls.is_mem = 1'b1; end
            CMD_CFG_RD:  begin cls.kind = T_CFG_RD;  cls.is_cfg = 1'b1; end
            CMD_CFG_WR:  begin cls.kind = T_CFG_WR;  cls.is_cfg = 1'b1; end
            CMD_DAC:     begin cls.kind = T_DAC;     cls.is_dac = 1'b1; end
            CMD_RSV4, CMD_RSV5, CMD_RSV8, CMD_RSV9:
                         cls.kind = T_RESERVED;
            default:     cls.kind = T_RESERVED;
        endcase
    end
endmodule

// File: rtl/apd_window_match.sv
module apd_window_match #(
    parameter int W          = 32,
    parameter int IGNORE_LSB = 0
) (
    input  logic [W-1:0] addr,
    input  logic [W-1:0] base,
    input  logic [W-1:0] mask,
    output logic         match
);
    logic [W-1:0] bit_ok;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i < IGNORE_LSB) begin : g_skip
            assign bit_ok[i] = 1'b1;
        end else begin : g_cmp
            assign bit_ok[i] = ~((addr[i] ^ base[i]) & mask[i]);
        end
    end

    assign match = &bit_ok;
endmodule

// File: rtl/addr_phase_decoder.sv
module addr_phase_decoder
    import apd_pkg::*;
#(
    parameter int AD_W   = 32,
    parameter int OFFS_W = 8,
    parameter int FUNC_W = 3,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [AD_W-1:0]   ad_in,
    input  logic [3:0]        cbe_in,
    input  logic              cfg_select,
    input  logic [AD_W-1:0]   io_base,
    input  logic [AD_W-1:0]   io_mask,
    input  logic [2*AD_W-1:0] mem_base,
    input  logic [2*AD_W-1:0] mem_mask,
    input  logic              intack_en,
    input  logic [VEC_W-1:0]  irq_vector,
    output logic              dec_valid,
    output logic [3:0]        txn_type,
    output logic              hit,
    output logic [OFFS_W-1:0] reg_offset,
    output logic [FUNC_W-1:0] cfg_func,
    output logic              vec_req,
    output logic [VEC_W-1:0]  vector_out
);
    localparam int ADDR64_W = 2 * AD_W;
    localparam int DW_LSB   = 2;
    localparam int FUNC_LSB = 8;

    st_e             state_q, state_d;
    logic [AD_W-1:0] lo_q;
    logic            dac_wait;

    cls_t                cls;
    logic [ADDR64_W-1:0] full_addr;
    logic                io_match, mem_match, go;
    logic                hit_d;
    logic [OFFS_W-1:0]   offs_d;
    logic [FUNC_W-1:0]   func_d;
    logic [AD_W-1:0]     io_rel;
    logic [ADDR64_W-1:0] mem_rel;

    assign dac_wait = (state_q == ST_DAC_HI);

    apd_cmd_classify u_cls (
        .code (cbe_in),
        .cls  (cls)
    );

    assign full_addr = dac_wait ? {ad_in, lo_q} : {{AD_W{1'b0}}, ad_in};

    apd_window_match #(.W(AD_W), .IGNORE_LSB(0)) u_io_win (
        .addr  (ad_in),
        .base  (io_base),
        .mask  (io_mask),
        .match (io_match)
    );

    apd_window_match #(.W(ADDR64_W), .IGNORE_LSB(DW_LSB)) u_mem_win (
        .addr  (full_addr),
        .base  (mem_base),
        .mask  (mem_mask),
        .match (mem_match)
    );

    assign io_rel  = ad_in & ~io_mask;
    assign mem_rel = full_addr & ~mem_mask;

    assign go = dac_wait || (frame_start && !cls.is_dac);

    // claim decision and offset selection
    always_comb begin
        hit_d  = 1'b0;
        offs_d = '0;
        func_d = '0;
        if (cls.is_mem) begin
            hit_d  = mem_match;
            offs_d = {mem_rel[OFFS_W-1:DW_LSB], {DW_LSB{1'b0}}};
        end else if (cls.is_io && !dac_wait) begin
            hit_d  = io_match;
            offs_d = io_rel[OFFS_W-1:0];
        end else if (cls.is_cfg && !dac_wait) begin
            hit_d  = cfg_select && (ad_in[DW_LSB-1:0] == '0);
            offs_d = {ad_in[OFFS_W-1:DW_LSB], {DW_LSB{1'b0}}};
            func_d = ad_in[FUNC_LSB +: FUNC_W];
        end else if (cls.is_intack && !dac_wait) begin
            hit_d  = intack_en;
        end
        if (!hit_d) begin
            offs_d = '0;
            func_d = '0;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (frame_start && cls.is_dac) state_d = ST_DAC_HI;
            ST_DAC_HI: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && frame_start && cls.is_dac) begin
                lo_q <= ad_in;
            end
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n || !go) begin
            dec_valid  <= 1'b0;
            txn_type   <= T_NONE;
            hit        <= 1'b0;
            reg_offset <= '0;
            cfg_func   <= '0;
            vec_req    <= 1'b0;
            vector_out <= '0;
        end else begin
            dec_valid  <= 1'b1;
            txn_type   <= cls.kind;
            hit        <= hit_d;
            reg_offset <= offs_d;
            cfg_func   <= func_d;
            vec_req    <= hit_d && cls.is_intack;
            vector_out <= (hit_d && cls.is_intack) ? irq_vector : '0;
        end
    end
endmodule

// File: rtl/apd_checker.sv
module apd_checker
    import apd_pkg::*;
#(
    parameter int OFFS_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic [3:0]        cbe_in,
    input logic              dac_wait,
    input logic              dec_valid,
    input logic [3:0]        txn_type,
    input logic              hit,
    input logic              vec_req,
    input logic [OFFS_W-1:0] reg_offset
);
    assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!hit && !vec_req && txn_type == T_NONE));

    assert_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_wait && frame_start && cbe_in != CMD_DAC) |=> (dec_valid && !dac_wait));

    assert_reserved_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && txn_type == T_RESERVED) |-> !hit);

    assert_mem_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && hit && (txn_type == T_MEM_RD || txn_type == T_MEM_WR))
            |-> (reg_offset[1:0] == 2'b00));

    assert_dac_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_wait && frame_start && cbe_in == CMD_DAC) |=> (dac_wait && !dec_valid));

    assert_dac_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dac_wait |=> (dec_valid && !dac_wait));

    assert_cfg_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && hit && (txn_type == T_CFG_RD || txn_type == T_CFG_WR))
            |-> (reg_offset[1:0] == 2'b00));

    assert_vec_intack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> (dec_valid && hit && txn_type == T_INTACK));

    assert_special_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && txn_type == T_SPECIAL) |-> !hit);
endmodule

bind addr_phase_decoder apd_checker #(.OFFS_W(OFFS_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .cbe_in      (cbe_in),
    .dac_wait    (dac_wait),
    .dec_valid   (dec_valid),
    .txn_type    (txn_type),
    .hit         (hit),
    .vec_req     (vec_req),
    .reg_offset  (reg_offset)
);

// File: tb/addr_phase_decoder_tb_top.sv
module addr_phase_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_in = '0;
    logic        cfg_select = 1'b0;
    logic [31:0] io_base = 32'h0000_1000;
    logic [31:0] io_mask = 32'hFFFF_FFF0;
    logic [63:0] mem_base = 64'h0000_0000_8000_0000;
    logic [63:0] mem_mask = 64'hFFFF_FFFF_FFF0_0000;
    logic        intack_en = 1'b1;
    logic [7:0]  irq_vector = 8'hA5;

    logic        dec_valid, hit, vec_req;
    logic [3:0]  txn_type;
    logic [7:0]  reg_offset, vector_out;
    logic [2:0]  cfg_func;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    addr_phase_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ad_in(ad_in),
        .cbe_in(cbe_in), .cfg_select(cfg_select), .io_base(io_base),
        .io_mask(io_mask), .mem_base(mem_base), .mem_mask(mem_mask),
        .intack_en(intack_en), .irq_vector(irq_vector), .dec_valid(dec_valid),
        .txn_type(txn_type), .hit(hit), .reg_offset(reg_offset),
        .cfg_func(cfg_func), .vec_req(vec_req), .vector_out(vector_out)
    );

    typedef struct packed {
        logic [3:0]  cbe;
        logic [31:0] ad;
        logic        sel;
        logic [3:0]  ty;
        logic        h;
        logic [7:0]  offs;
        logic [2:0]  fn;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{4'b0010, 32'h0000_1007, 1'b0, 4'd3,  1'b1, 8'h07, 3'd0}, // R4 io hit
        '{4'b0011, 32'h0000_1020, 1'b0, 4'd4,  1'b0, 8'h00, 3'd0}, // R4 io miss
        '{4'b0110, 32'h8001_2347, 1'b0, 4'd5,  1'b1, 8'h44, 3'd0}, // R5 mem rd
        '{4'b0111, 32'h9000_0000, 1'b0, 4'd6,  1'b0, 8'h00, 3'd0}, // R5 mem miss
        '{4'b1100, 32'h8000_00FC, 1'b0, 4'd5,  1'b1, 8'hFC, 3'd0}, // R2 multiple
        '{4'b1110, 32'h8000_0010, 1'b0, 4'd5,  1'b1, 8'h10, 3'd0}, // R2 line
        '{4'b1111, 32'h800F_FFFF, 1'b0, 4'd6,  1'b1, 8'hFC, 3'd0}, // R2 invalidate
        '{4'b1010, 32'h0000_0534, 1'b1, 4'd7,  1'b1, 8'h34, 3'd5}, // R8 cfg rd
        '{4'b1011, 32'h0000_0708, 1'b1, 4'd8,  1'b1, 8'h08, 3'd7}, // R8 cfg wr
        '{4'b1010, 32'h0000_0534, 1'b0, 4'd7,  1'b0, 8'h00, 3'd0}, // R9 no select
        '{4'b1010, 32'h0000_0535, 1'b1, 4'd7,  1'b0, 8'h00, 3'd0}, // R9 misaligned
        '{4'b0100, 32'h8000_0000, 1'b1, 4'd9,  1'b0, 8'h00, 3'd0}, // R3
        '{4'b0101, 32'h8000_0000, 1'b1, 4'd9,  1'b0, 8'h00, 3'd0}, // R3
        '{4'b1000, 32'h8000_0000, 1'b1, 4'd9,  1'b0, 8'h00, 3'd0}, // R3
        '{4'b1001, 32'h8000_0000, 1'b1, 4'd9,  1'b0, 8'h00, 3'd0}, // R3
        '{4'b0001, 32'h0000_0000, 1'b1, 4'd2,  1'b0, 8'h00, 3'd0}, // R11
        '{4'b0000, 32'h0000_0000, 1'b0, 4'd1,  1'b1, 8'h00, 3'd0}  // R10
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // one start cycle; returns at the negedge where the result is visible
    task automatic start(input logic [3:0] c, input logic [31:0] a, input logic s);
        @(negedge clk);
        frame_start = 1'b1; cbe_in = c; ad_in = a; cfg_select = s;
        @(posedge clk);
        @(negedge clk);
        frame_start = 1'b0; cbe_in = 4'b0100; ad_in = '0; cfg_select = 1'b0;
    endtask

    // dual address: low half with 1101, then upper half with real command
    task automatic dual(input logic [31:0] lo, input logic [31:0] hi, input logic [3:0] c2,
                        input logic strobe2);
        @(negedge clk);
        frame_start = 1'b1; cbe_in = 4'b1101; ad_in = lo; cfg_select = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R6 no decode in first cycle", dec_valid, 1'b0);
        frame_start = strobe2; cbe_in = c2; ad_in = hi;
        @(posedge clk);
        @(negedge clk);
        frame_start = 1'b0; cbe_in = 4'b0100; ad_in = '0; cfg_select = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset dec_valid", dec_valid, 1'b0);
        chk("R1 reset hit", hit, 1'b0);
        chk("R1 reset type", txn_type, 4'd0);
        chk("R1 reset vec_req", vec_req, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            start(TBL[i].cbe, TBL[i].ad, TBL[i].sel);
            chk("R2 valid pulse", dec_valid, 1'b1);
            chk("R2 type", txn_type, TBL[i].ty);
            chk("R3/R4/R5/R8/R9/R11 hit", hit, TBL[i].h);
            chk("R4/R5/R8 offset", reg_offset, TBL[i].offs);
            chk("R8 func", cfg_func, TBL[i].fn);
            @(negedge clk);
            chk("R1 idle after decode", {dec_valid, hit, txn_type}, 6'd0);
        end

        // R10 interrupt acknowledge enabled and disabled
        start(4'b0000, 32'h0, 1'b0);
        chk("R10 vec_req", vec_req, 1'b1);
        chk("R10 vector", vector_out, 8'hA5);
        intack_en = 1'b0;
        start(4'b0000, 32'h0, 1'b0);
        chk("R10 disabled hit", hit, 1'b0);
        chk("R10 disabled vec_req", vec_req, 1'b0);
        chk("R10 disabled vector", vector_out, 8'h00);
        intack_en = 1'b1;

        // R4 bits 1:0 are compared for I/O
        io_mask = 32'hFFFF_FFFF;
        start(4'b0010, 32'h0000_1003, 1'b0);
        chk("R4 low bits differ miss", hit, 1'b0);
        start(4'b0011, 32'h0000_1000, 1'b0);
        chk("R4 exact hit", hit, 1'b1);
        io_mask = 32'hFFFF_FFF0;

        // R5 bits 1:0 ignored for memory
        mem_mask = 64'hFFFF_FFFF_FFFF_FFFF;
        start(4'b0110, 32'h8000_0003, 1'b0);
        chk("R5 low bits ignored hit", hit, 1'b1);
        chk("R5 offset", reg_offset, 8'h00);
        mem_mask = 64'hFFFF_FFFF_FFF0_0000;

        // R6 dual address, strobe in second cycle ignored
        dual(32'h8000_0040, 32'h0000_0000, 4'b0110, 1'b1);
        chk("R6 valid", dec_valid, 1'b1);
        chk("R6 type", txn_type, 4'd5);
        chk("R6 hit", hit, 1'b1);
        chk("R6 offset", reg_offset, 8'h40);
        @(negedge clk);
        chk("R6 no restart", dec_valid, 1'b0);

        // R6 upper half mismatch
        dual(32'h8000_0040, 32'h0000_0001, 4'b0111, 1'b0);
        chk("R6 hi mismatch type", txn_type, 4'd6);
        chk("R6 hi mismatch miss", hit, 1'b0);

        // R6 upper half matched in a high window
        mem_base = 64'h0000_0002_8000_0000;
        dual(32'h8000_0008, 32'h0000_0002, 4'b1111, 1'b0);
        chk("R6 high window hit", hit, 1'b1);
        mem_base = 64'h0000_0000_8000_0000;

        // R7 non-memory after dual address
        dual(32'h0000_1004, 32'h0000_0000, 4'b0010, 1'b0);
        chk("R7 io type", txn_type, 4'd3);
        chk("R7 io miss", hit, 1'b0);
        dual(32'h0000_0100, 32'h0000_0000, 4'b1010, 1'b0);
        chk("R7 cfg miss", hit, 1'b0);
        dual(32'h8000_0000, 32'h0000_0000, 4'b0000, 1'b0);
        chk("R7 intack miss", {hit, vec_req}, 2'b00);
        dual(32'h8000_0000, 32'h0000_0000, 4'b1101, 1'b0);
        chk("R7 repeated dual type", txn_type, 4'd10);
        chk("R7 repeated dual miss", hit, 1'b0);

        // R1 reset mid-stream clears outputs
        @(negedge clk);
        frame_start = 1'b1; cbe_in = 4'b0110; ad_in = 32'h8000_0000;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        frame_start = 1'b0;
        chk("R1 reset overrides start", {dec_valid, hit}, 2'b00);
        rst_n = 1'b1;

        summary();
    end

endmodule